// File: doc/BRIEF.md
# Bit-Reversed Write Address Generator

This block computes the effective address and the pointer writeback value for a single indirect data access. It serves a write-side address unit that must reorder data for radix-2 FFT passes. Each request brings a pointer value, an addressing mode, the index of the pointer register, a data size, a read/write flag and a register offset. A global enable and a 15-bit pivot control the bit-reversed feature. A base/limit window controls optional modulo correction.

Bit-reversed generation engages only for a narrow class of accesses: word-sized writes, through a register other than the stack pointer, in pre-increment or post-increment mode, with the enable set. In that case the pointer advances by adding the pivot with the carry running from higher to lower bit positions. The register offset and the modulo window are both ignored. Every other request gets a normal address: a plain step, an offset add, and modulo correction where it is enabled. Results appear on registered outputs one clock after the request.

Top module: `bitrev_agu`

## Requirements
- R1: `brev_active` is 1 exactly when the request is valid, `req_brev_en`=1, `req_reg_idx`≠15, `req_write`=1, `req_word`=1 and `req_mode` is post-increment (3) or pre-increment (5). Otherwise it is 0 and the request is served normally.
- R2: For a bit-reversed post-increment, `ea_addr` is the pointer with bit 0 cleared. `wb_value` is the reverse-carry sum and `wb_en`=1.
- R3: For a bit-reversed pre-increment, `ea_addr` and `wb_value` both equal the reverse-carry sum, and `wb_en`=1.
- R4: While bit-reversed mode is active, `req_offset` has no effect on any output.
- R5: While bit-reversed mode is active, bit 0 of both `ea_addr` and `wb_value` is 0, even for an odd pointer.
- R6: The reverse-carry sum adds the pivot, counted in words (pivot shifted left by one into byte units), to pointer bits 15..1. A carry moves from each bit to the next lower one, and a carry out of bit 1 is dropped. Pointer bits above the pivot's highest set bit pass through unchanged. From a base of 0x0100 with pivot 4, repeated post-increments visit word indices 0,4,2,6,1,5,3,7 and then wrap to 0.
- R7: Mode codes are 0 direct, 1 indirect, 2 post-decrement, 3 post-increment, 4 pre-decrement, 5 pre-increment, 6 register offset, and 7 acts as indirect. The step is 2 for words and 1 for bytes. Pre modes present the stepped address. Post modes present the pointer and write back the stepped value. Modes 0, 1, 6 and 7 give `wb_en`=0 and `wb_value`=0.
- R8: With `req_mod_en`=1 and bit-reversed mode inactive, a stepped or offset address above `req_mod_end` has (end−start+1) subtracted, and one below `req_mod_start` has it added. The check uses strict comparison, so a jump past a boundary is still corrected. Mode 6 computes the corrected address but never writes back.
- R9: When bit-reversed mode is active, modulo correction is not applied even if `req_mod_en`=1.
- R10: Outputs register the result of the request one clock after it. `ea_valid` follows `req_valid`, and all outputs are 0 when the preceding request was not valid. Reset (`rst_n`=0) clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = data write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_mode | input | 3 | Addressing mode code |
| req_reg_idx | input | 4 | Index of the pointer register |
| req_ptr | input | 16 | Pointer register value (byte address) |
| req_offset | input | 16 | Register offset for mode 6 |
| req_brev_en | input | 1 | Bit-reversed mode enable |
| req_brev_pivot | input | 15 | Reverse-carry modifier in words |
| req_mod_en | input | 1 | Modulo correction enable |
| req_mod_start | input | 16 | Modulo window lower bound |
| req_mod_end | input | 16 | Modulo window upper bound |
| ea_valid | output | 1 | Registered request valid |
| ea_addr | output | 16 | Effective address |
| wb_en | output | 1 | Pointer writeback required |
| wb_value | output | 16 | Pointer writeback value |
| brev_active | output | 1 | Bit-reversed path was used |

## Verification
Bit-reversed generation and modulo correction can both be requested in the same cycle. The collision is provoked with a qualifying word write whose reverse-carry result lands outside an enabled modulo window. The bench expects the uncorrected reverse-carry value, and `brev_active` must be 1. The same window and pointer are then used for a word read, which must be wrapped by modulo correction, showing that the override applies only where bit reversal is actually engaged.

// File: rtl/bitrev_agu_pkg.sv
package bitrev_agu_pkg;

   typedef enum logic [2:0] {
      AM_DIRECT  = 3'd0,
      AM_IND     = 3'd1,
      AM_POSTDEC = 3'd2,
      AM_POSTINC = 3'd3,
      AM_PREDEC  = 3'd4,
      AM_PREINC  = 3'd5,
      AM_OFFSET  = 3'd6,
      AM_RSVD    = 3'd7
   } amode_e;

   function automatic logic is_inc_mode(input amode_e m);
      return (m == AM_POSTINC) || (m == AM_PREINC);
   endfunction

endpackage

// File: rtl/bitrev_agu_qualify.sv
module bitrev_agu_qualify
   import bitrev_agu_pkg::*;
#(
   parameter int IDX_W     = 4,
   parameter int STACK_IDX = 15
) (
   input  logic             brev_en,
   input  logic [IDX_W-1:0] reg_idx,
   input  logic             is_write,
   input  logic             is_word,
   input  amode_e           mode,
   output logic             engage
);
   localparam logic [IDX_W-1:0] STACK_CODE = IDX_W'(STACK_IDX);

   logic not_stack;
   logic access_ok;

   always_comb begin
      not_stack = (reg_idx != STACK_CODE);
      access_ok = is_write && is_word && is_inc_mode(mode);
      engage    = brev_en && not_stack && access_ok;
   end
endmodule

// File: rtl/bitrev_agu_revadd.sv
module bitrev_agu_revadd #(
   parameter int W = 15
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   // cin[i] is the carry arriving at bit i from bit i+1 (reverse direction)
   logic [W-1:0] cin;

   assign cin[W-1] = 1'b0;

   for (genvar i = W - 1; i >= 1; i--) begin : g_bit
      assign sum[i]   = a[i] ^ b[i] ^ cin[i];
      assign cin[i-1] = (a[i] & b[i]) | (cin[i] & (a[i] ^ b[i]));
   end

   assign sum[0] = a[0] ^ b[0] ^ cin[0];
endmodule

// File: rtl/bitrev_agu_normal.sv
module bitrev_agu_normal
   import bitrev_agu_pkg::*;
#(
   parameter int AW = 16
) (
   input  amode_e          mode,
   input  logic [AW-1:0]   ptr,
   input  logic [AW-1:0]   offset,
   input  logic            is_word,
   output logic [AW-1:0]   nxt,
   output logic            ea_from_nxt,
   output logic            wb_req
);
   localparam int STEP_PAD = AW - 2;

   logic [AW-1:0] step;

   always_comb begin
      step        = {{STEP_PAD{1'b0}}, is_word, ~is_word};
      nxt         = ptr;
      ea_from_nxt = 1'b0;
      wb_req      = 1'b0;
      unique case (mode)
         AM_POSTINC: begin nxt = ptr + step; wb_req = 1'b1; end
         AM_PREINC:  begin nxt = ptr + step; wb_req = 1'b1; ea_from_nxt = 1'b1; end
         AM_POSTDEC: begin nxt = ptr - step; wb_req = 1'b1; end
         AM_PREDEC:  begin nxt = ptr - step; wb_req = 1'b1; ea_from_nxt = 1'b1; end
         AM_OFFSET:  begin nxt = ptr + offset; ea_from_nxt = 1'b1; end
         default:    begin nxt = ptr; end
      endcase
   end
endmodule

// File: rtl/bitrev_agu_modulo.sv
module bitrev_agu_modulo #(
   parameter int AW = 16
) (
   input  logic            en,
   input  logic [AW-1:0]   addr,
   input  logic [AW-1:0]   lo,
   input  logic [AW-1:0]   hi,
   output logic [AW-1:0]   fixed
);
   logic [AW-1:0] span;
   logic          over;
   logic          under;

   always_comb begin
      span  = hi - lo + AW'(1);
      over  = addr > hi;
      under = addr < lo;
      if (en && over)
         fixed = addr - span;
      else if (en && under)
         fixed = addr + span;
      else
         fixed = addr;
   end
endmodule

// File: rtl/bitrev_agu.sv
module bitrev_agu
   import bitrev_agu_pkg::*;
#(
   parameter int AW        = 16,
   parameter int PW        = 15,
   parameter int IDX_W     = 4,
   parameter int STACK_IDX = 15,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             req_word,
   input  logic [2:0]       req_mode,
   input  logic [IDX_W-1:0] req_reg_idx,
   input  logic [AW-1:0]    req_ptr,
   input  logic [AW-1:0]    req_offset,
   input  logic             req_brev_en,
   input  logic [PW-1:0]    req_brev_pivot,
   input  logic             req_mod_en,
   input  logic [AW-1:0]    req_mod_start,
   input  logic [AW-1:0]    req_mod_end,
   output logic             ea_valid,
   output logic [AW-1:0]    ea_addr,
   output logic             wb_en,
   output logic [AW-1:0]    wb_value,
   output logic             brev_active
);
   localparam int WAW = AW - 1;

   if (PW != WAW) begin : g_bad_pw
      $error("pivot width must equal word-address width");
   end
   if (AW < 4) begin : g_bad_aw
      $error("address width too small");
   end
   if (STACK_IDX >= (1 << IDX_W)) begin : g_bad_idx
      $error("stack index does not fit the register index");
   end

   amode_e        mode;
   logic          engage;
   logic [AW-1:0] nrm_nxt;
   logic          nrm_ea_nxt;
   logic          nrm_wb;
   logic [AW-1:0] mod_fixed;
   logic [WAW-1:0] rev_sum;
   logic [AW-1:0] rev_byte;
   logic [AW-1:0] ptr_even;

   logic [AW-1:0] c_ea;
   logic [AW-1:0] c_wb;
   logic          c_wb_en;
   logic          c_brev;

   assign mode = amode_e'(req_mode);

   bitrev_agu_qualify #(.IDX_W(IDX_W), .STACK_IDX(STACK_IDX)) u_qual (
      .brev_en  (req_brev_en),
      .reg_idx  (req_reg_idx),
      .is_write (req_write),
      .is_word  (req_word),
      .mode     (mode),
      .engage   (engage)
   );

   bitrev_agu_normal #(.AW(AW)) u_norm (
      .mode        (mode),
      .ptr         (req_ptr),
      .offset      (req_offset),
      .is_word     (req_word),
      .nxt         (nrm_nxt),
      .ea_from_nxt (nrm_ea_nxt),
      .wb_req      (nrm_wb)
   );

   bitrev_agu_modulo #(.AW(AW)) u_mod (
      .en    (req_mod_en && !engage),
      .addr  (nrm_nxt),
      .lo    (req_mod_start),
      .hi    (req_mod_end),
      .fixed (mod_fixed)
   );

   bitrev_agu_revadd #(.W(WAW)) u_rev (
      .a   (req_ptr[AW-1:1]),
      .b   (req_brev_pivot),
      .sum (rev_sum)
   );

   always_comb begin
      rev_byte = {rev_sum, 1'b0};
      ptr_even = {req_ptr[AW-1:1], 1'b0};
      c_brev   = req_valid && engage;
      c_wb_en  = 1'b0;
      c_ea     = '0;
      c_wb     = '0;
      if (req_valid) begin
         if (engage) begin
            c_ea    = (mode == AM_PREINC) ? rev_byte : ptr_even;
            c_wb    = rev_byte;
            c_wb_en = 1'b1;
         end else begin
            c_ea    = nrm_ea_nxt ? mod_fixed : req_ptr;
            c_wb    = nrm_wb ? mod_fixed : '0;
            c_wb_en = nrm_wb;
         end
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ea_valid    <= 1'b0;
            ea_addr     <= '0;
            wb_en       <= 1'b0;
            wb_value    <= '0;
            brev_active <= 1'b0;
         end else begin
            ea_valid    <= req_valid;
            ea_addr     <= c_ea;
            wb_en       <= c_wb_en;
            wb_value    <= c_wb;
            brev_active <= c_brev;
         end
      end

      function automatic logic [AW-1:0] span_mask(input logic [PW-1:0] p);
         logic [PW-1:0] s;
         s = p;
         for (int i = 1; i < PW; i++) s = s | (s >> 1);
         return {s, 1'b1};
      endfunction

      p_valid_pipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (ea_valid == $past(req_valid)));

      p_qualify_r1: assert property (@(posedge clk) disable iff (!rst_n)
         brev_active |-> ($past(req_reg_idx) != IDX_W'(STACK_IDX))
                         && $past(req_write) && $past(req_word) && $past(req_brev_en));

      p_lsb_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
         brev_active |-> (!ea_addr[0] && !wb_value[0] && wb_en));

      p_post_ea_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (brev_active && $past(req_mode) == 3'(AM_POSTINC))
            |-> (ea_addr == {$past(req_ptr[AW-1:1]), 1'b0}));

      p_pre_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (brev_active && $past(req_mode) == 3'(AM_PREINC)) |-> (ea_addr == wb_value));

      p_high_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
         brev_active |-> (((wb_value ^ {$past(req_ptr[AW-1:1]), 1'b0})
                           & ~span_mask($past(req_brev_pivot))) == '0));

      p_offset_nowb_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (ea_valid && $past(req_mode) == 3'(AM_OFFSET)) |-> !wb_en);
   end else begin : g_comb
      assign ea_valid    = req_valid;
      assign ea_addr     = c_ea;
      assign wb_en       = c_wb_en;
      assign wb_value    = c_wb;
      assign brev_active = c_brev;
   end
endmodule

// File: tb/bitrev_agu_tb.sv
`timescale 1ns/1ps
module bitrev_agu_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, req_word, req_brev_en, req_mod_en;
   logic [2:0]  req_mode;
   logic [3:0]  req_reg_idx;
   logic [15:0] req_ptr, req_offset, req_mod_start, req_mod_end;
   logic [14:0] req_brev_pivot;
   logic        ea_valid, wb_en, brev_active;
   logic [15:0] ea_addr, wb_value;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   bitrev_agu u_dut (.*);

   typedef struct packed {
      logic wr; logic wd; logic [2:0] md; logic [3:0] idx;
      logic [15:0] ptr; logic [15:0] off; logic en; logic [14:0] piv;
      logic me; logic [15:0] ms; logic [15:0] mend;
      logic [15:0] x_ea; logic x_wbe; logic [15:0] x_wb; logic x_br; logic [7:0] tag;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      // R2: postinc word write, index 4 -> 2
      '{1,1,3'd3,4'd2,16'h0108,16'h0000,1,15'd4,0,16'h0,16'h0,16'h0108,1,16'h0104,1,8'd2},
      // R3: preinc, index 6 -> 1
      '{1,1,3'd5,4'd2,16'h010C,16'h0000,1,15'd4,0,16'h0,16'h0,16'h0102,1,16'h0102,1,8'd3},
      // R1: stack register excluded
      '{1,1,3'd3,4'd15,16'h0100,16'h0000,1,15'd4,0,16'h0,16'h0,16'h0100,1,16'h0102,0,8'd1},
      // R1: byte write excluded
      '{1,0,3'd3,4'd2,16'h0100,16'h0000,1,15'd4,0,16'h0,16'h0,16'h0100,1,16'h0101,0,8'd1},
      // R1: read excluded
      '{0,1,3'd3,4'd2,16'h0100,16'h0000,1,15'd4,0,16'h0,16'h0,16'h0100,1,16'h0102,0,8'd1},
      // R1: enable clear
      '{1,1,3'd5,4'd2,16'h0100,16'h0000,0,15'd4,0,16'h0,16'h0,16'h0102,1,16'h0102,0,8'd1},
      // R1: postdec excluded
      '{1,1,3'd2,4'd2,16'h0100,16'h0000,1,15'd4,0,16'h0,16'h0,16'h0100,1,16'h00FE,0,8'd1},
      // R4: offset ignored
      '{1,1,3'd3,4'd2,16'h0100,16'h0040,1,15'd4,0,16'h0,16'h0,16'h0100,1,16'h0108,1,8'd4},
      // R5: odd pointer, lsb cleared
      '{1,1,3'd3,4'd2,16'h0101,16'h0000,1,15'd4,0,16'h0,16'h0,16'h0100,1,16'h0108,1,8'd5},
      // R6: carry dropped, high bits kept
      '{1,1,3'd3,4'd2,16'hA10E,16'h0000,1,15'd4,0,16'h0,16'h0,16'hA10E,1,16'hA100,1,8'd6},
      // R6: large pivot
      '{1,1,3'd3,4'd2,16'h0000,16'h0000,1,15'h0400,0,16'h0,16'h0,16'h0000,1,16'h0800,1,8'd6},
      // R7: direct
      '{0,0,3'd0,4'd1,16'h1234,16'h0000,0,15'd0,0,16'h0,16'h0,16'h1234,0,16'h0000,0,8'd7},
      // R7: indirect
      '{0,1,3'd1,4'd1,16'h1234,16'h0000,0,15'd0,0,16'h0,16'h0,16'h1234,0,16'h0000,0,8'd7},
      // R7: predec byte
      '{1,0,3'd4,4'd1,16'h1234,16'h0000,0,15'd0,0,16'h0,16'h0,16'h1233,1,16'h1233,0,8'd7},
      // R7: offset without modulo
      '{0,1,3'd6,4'd1,16'h0200,16'h0010,0,15'd0,0,16'h0,16'h0,16'h0210,0,16'h0000,0,8'd7},
      // R8: postinc wraps above end
      '{0,1,3'd3,4'd1,16'h021E,16'h0000,0,15'd0,1,16'h0200,16'h021F,16'h021E,1,16'h0200,0,8'd8},
      // R8: predec wraps below start
      '{1,1,3'd4,4'd1,16'h0200,16'h0000,0,15'd0,1,16'h0200,16'h021F,16'h021E,1,16'h021E,0,8'd8},
      // R8: offset jumps past end
      '{0,1,3'd6,4'd1,16'h0218,16'h000C,0,15'd0,1,16'h0200,16'h021F,16'h0204,0,16'h0000,0,8'd8},
      // R9: bit reversal overrides modulo
      '{1,1,3'd3,4'd3,16'h0200,16'h0000,1,15'h0010,1,16'h0200,16'h020F,16'h0200,1,16'h0220,1,8'd9},
      // R9: read with same setup still wraps
      '{0,1,3'd3,4'd3,16'h020E,16'h0000,1,15'h0010,1,16'h0200,16'h020F,16'h020E,1,16'h0200,0,8'd9}
   };

   task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      req_valid = 0; req_write = 0; req_word = 0; req_mode = 3'd0; req_reg_idx = 4'd0;
      req_ptr = '0; req_offset = '0; req_brev_en = 0; req_brev_pivot = '0;
      req_mod_en = 0; req_mod_start = '0; req_mod_end = '0;
   endtask

   task automatic apply(input vec_t v);
      req_valid = 1; req_write = v.wr; req_word = v.wd; req_mode = v.md; req_reg_idx = v.idx;
      req_ptr = v.ptr; req_offset = v.off; req_brev_en = v.en; req_brev_pivot = v.piv;
      req_mod_en = v.me; req_mod_start = v.ms; req_mod_end = v.mend;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R10 watchdog: actual=hung expected=complete");
      finish_run();
   end

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "reset ea_valid", {15'd0, ea_valid}, 16'd0);
      chk("R10", "reset ea_addr", ea_addr, 16'd0);
      chk("R10", "reset wb", {15'd0, wb_en} | wb_value, 16'd0);
      rst_n = 1;

      for (int k = 0; k < NV; k++) begin
         apply(VECS[k]);
         @(negedge clk);
         chk($sformatf("R%0d", VECS[k].tag), $sformatf("v%0d ea", k), ea_addr, VECS[k].x_ea);
         chk($sformatf("R%0d", VECS[k].tag), $sformatf("v%0d wb_en", k), {15'd0, wb_en}, {15'd0, VECS[k].x_wbe});
         chk($sformatf("R%0d", VECS[k].tag), $sformatf("v%0d wb", k), wb_value, VECS[k].x_wb);
         chk($sformatf("R%0d", VECS[k].tag), $sformatf("v%0d brev", k), {15'd0, brev_active}, {15'd0, VECS[k].x_br});
      end

      // R6: bit-reversed visiting order over an 8-word buffer, then wrap
      begin
         logic [15:0] p;
         p = 16'h0100;
         for (int k = 0; k < 9; k++) begin
            logic [2:0] kk;
            logic [2:0] rv;
            kk = 3'(k % 8);
            rv = {kk[0], kk[1], kk[2]};
            req_valid = 1; req_write = 1; req_word = 1; req_mode = 3'd3; req_reg_idx = 4'd5;
            req_ptr = p; req_offset = '0; req_brev_en = 1; req_brev_pivot = 15'd4;
            req_mod_en = 0;
            @(negedge clk);
            chk("R6", $sformatf("order step %0d", k), ea_addr, 16'h0100 + 16'(rv) * 16'd2);
            p = wb_value;
         end
      end

      // R10: invalid request leaves outputs at zero
      idle();
      req_ptr = 16'h5555; req_brev_en = 1; req_write = 1; req_word = 1; req_mode = 3'd3;
      @(negedge clk);
      chk("R10", "idle ea_valid", {15'd0, ea_valid}, 16'd0);
      chk("R10", "idle ea_addr", ea_addr, 16'd0);

      // R10: reset in the middle of traffic
      apply(VECS[0]);
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      chk("R10", "mid reset brev", {15'd0, brev_active}, 16'd0);
      chk("R10", "mid reset wb_value", wb_value, 16'd0);
      rst_n = 1;
      idle();
      @(negedge clk);
      finish_run();
   end
endmodule